// File: doc/BRIEF.md
# Byte-Wide Register Port with Auto-Stepping Pointers

This block sits between an 8-bit processor bus and a set of identical channels, each holding four 24-bit registers (a counter value, a first reference, a preload value and a second reference) plus a 24-bit capture value supplied by the channel. The processor never addresses a byte directly. It writes a command to set where a write pointer starts, and then it streams data bytes. Each byte lands at the pointer position, and the pointer steps to the next byte. The capture value is read the same way: successive data reads return its low, middle and high bytes and then begin again at the low byte.

A select line picks the access type. With the select line at 1, a write is a command and a read returns a status byte. With it at 0, a write is register data and a read returns capture data. Every channel has an active-low enable. A write goes to every enabled channel at once. A read drives the bus only when exactly one channel is enabled. Each access takes effect at the rising edge of its active-low strobe, sampled on the system clock.

A three-state strobe machine tracks the strobes. IDLE moves to WRITE when the write strobe is low and the read strobe is high. IDLE moves to READ when the read strobe is low and the write strobe is high. WRITE returns to IDLE when the write strobe rises, and this transition commits the write. READ returns to IDLE when the read strobe rises, and this transition steps the read index. When both strobes are low together, IDLE stays in IDLE.

Top module: `bytebus_ptr_port`

## Requirements
- R1: After reset, every channel's write pointer is 0, its read index is 0, its mode is 0 and all four registers are 0, so its status byte reads 0x00.
- R2: A command write (select=1) loads the write pointer from data bits [3:0] and the mode from data bit 4, and it clears the read index. If the start value is past the last index valid for the new mode (8 in mode 0, 11 in mode 1), the pointer loads 0 instead.
- R3: A data write (select=0) stores the data byte at the write pointer and then adds 1 to the pointer. Index 0-2 is the counter value low/mid/high, 3-5 is reference A, 6-8 is the preload value and 9-11 is reference B.
- R4: In mode 0 the pointer returns to 0 after index 8, so reference B is never written.
- R5: In mode 1 the pointer continues through indices 9-11 after index 8 and then returns to 0.
- R6: A data read (select=0) returns the capture byte at the read index (0 low, 1 middle, 2 high). The index advances when the read strobe rises and returns to 0 after the high byte.
- R7: A status read (select=1) returns {1'b0, read index[1:0], mode, write pointer[3:0]} and changes no pointer.
- R8: A write affects every channel whose enable is low and leaves every other channel unchanged.
- R9: dout_en is 1 only while the read strobe is low and exactly one enable is low. A read with no enable or with several enables drives nothing and moves no read index.
- R10: A strobe held low for many clock cycles performs exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | NCH | Per-channel enable, active low |
| cd | input | 1 | 1 = command/status, 0 = data/capture |
| wr_n | input | 1 | Write strobe, active low, acts on rising edge |
| rd_n | input | 1 | Read strobe, active low, acts on rising edge |
| din | input | 8 | Write data byte |
| dout | output | 8 | Read data byte |
| dout_en | output | 1 | Bus drive enable (0 = high impedance) |
| latch_in | input | NCH*REGW | Capture value of each channel |
| cnt_out | output | NCH*REGW | Counter value register of each channel |
| refa_out | output | NCH*REGW | Reference A of each channel |
| pre_out | output | NCH*REGW | Preload register of each channel |
| refb_out | output | NCH*REGW | Reference B of each channel |

## Verification
The bench checks the two wrap points of the write sequence. A design that ignored the mode would spill bytes into reference B in mode 0, or would stop at the preload in mode 1. The bench sends a command whose start value is out of range for mode 0, which a careless design would accept and leave at an index that cannot be reached. It checks that status reads and reads with several channels enabled leave the capture index alone, where a wrong design would skip a byte. It holds a strobe low for many cycles and broadcasts a write to two channels, which catches a design that acts on a level instead of an edge or that writes only the lowest-numbered channel.

// File: rtl/bytebus_ptr_pkg.sv
package bytebus_ptr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } strobe_st_t;

    // register groups reachable by the write pointer, in sequence order
    localparam int GROUPS      = 4;
    // groups reachable in mode 0 (counter, reference A, preload)
    localparam int GROUPS_MODE0 = 3;
endpackage

// File: rtl/bytebus_strobe_fsm.sv
module bytebus_strobe_fsm
    import bytebus_ptr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    input  logic rd_n,
    output logic wr_done,
    output logic rd_done
);
    strobe_st_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        wr_done  = 1'b0;
        rd_done  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!wr_n && rd_n)      state_nx = ST_WRITE;
                else if (!rd_n && wr_n) state_nx = ST_READ;
            end
            ST_WRITE: begin
                if (wr_n) begin
                    wr_done  = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            ST_READ: begin
                if (rd_n) begin
                    rd_done  = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/bytebus_chan_regs.sv
module bytebus_chan_regs
    import bytebus_ptr_pkg::*;
#(
    parameter int REGW = 24,
    parameter int PW   = 4,
    parameter int RW   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sel,
    input  logic                              rd_single,
    input  logic                              cd,
    input  logic [7:0]                        din,
    input  logic                              wr_done,
    input  logic                              rd_done,
    input  logic [REGW-1:0]                   latch,
    output logic [GROUPS-1:0][REGW-1:0]       grp_val,
    output logic [PW-1:0]                     wr_ptr,
    output logic                              mode,
    output logic [7:0]                        rd_byte,
    output logic [7:0]                        status
);
    localparam int BYTES = REGW / 8;
    localparam logic [PW-1:0] LAST0 = PW'(GROUPS_MODE0 * BYTES - 1);
    localparam logic [PW-1:0] LAST1 = PW'(GROUPS * BYTES - 1);
    localparam logic [RW-1:0] RLAST = RW'(BYTES - 1);

    logic [7:0]    bank [GROUPS][BYTES];
    logic [RW-1:0] rd_idx;
    logic [PW-1:0] cmd_start;
    logic          cmd_mode;
    logic [PW-1:0] ptr_last;

    assign cmd_start = din[PW-1:0];
    assign cmd_mode  = din[PW];
    assign ptr_last  = mode ? LAST1 : LAST0;

    // write pointer, mode and register bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            mode   <= 1'b0;
            for (int g = 0; g < GROUPS; g++)
                for (int b = 0; b < BYTES; b++)
                    bank[g][b] <= '0;
        end else if (wr_done && sel) begin
            if (cd) begin
                mode <= cmd_mode;
                if (cmd_start > (cmd_mode ? LAST1 : LAST0)) wr_ptr <= '0;
                else                                         wr_ptr <= cmd_start;
            end else begin
                for (int g = 0; g < GROUPS; g++)
                    for (int b = 0; b < BYTES; b++)
                        if (wr_ptr == PW'(g * BYTES + b)) bank[g][b] <= din;
                wr_ptr <= (wr_ptr >= ptr_last) ? '0 : wr_ptr + PW'(1);
            end
        end
    end

    // capture read index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_idx <= '0;
        end else if (wr_done && sel && cd) begin
            rd_idx <= '0;
        end else if (rd_done && rd_single && !cd) begin
            rd_idx <= (rd_idx >= RLAST) ? '0 : rd_idx + RW'(1);
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int b = 0; b < BYTES; b++)
            if (rd_idx == RW'(b)) rd_byte = latch[b*8 +: 8];
    end

    assign status = 8'({rd_idx, mode, wr_ptr});

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            assign grp_val[g][b*8 +: 8] = bank[g][b];
        end
    end
endmodule

// File: rtl/bytebus_rd_mux.sv
module bytebus_rd_mux #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0]      ce_n,
    input  logic                rd_n,
    input  logic                cd,
    input  logic [NCH-1:0][7:0] rd_byte_all,
    input  logic [NCH-1:0][7:0] status_all,
    output logic [NCH-1:0]      one_sel,
    output logic [7:0]          dout,
    output logic                dout_en
);
    int n_en;

    always_comb begin
        n_en = 0;
        for (int i = 0; i < NCH; i++)
            if (!ce_n[i]) n_en = n_en + 1;
        one_sel = (n_en == 1) ? ~ce_n : '0;
        dout_en = !rd_n && (n_en == 1);
        dout    = '0;
        for (int i = 0; i < NCH; i++)
            if (one_sel[i]) dout = cd ? status_all[i] : rd_byte_all[i];
    end
endmodule

// File: rtl/bytebus_ptr_port.sv
module bytebus_ptr_port
    import bytebus_ptr_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int REGW = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      ce_n,
    input  logic                cd,
    input  logic                wr_n,
    input  logic                rd_n,
    input  logic [7:0]          din,
    output logic [7:0]          dout,
    output logic                dout_en,
    input  logic [NCH*REGW-1:0] latch_in,
    output logic [NCH*REGW-1:0] cnt_out,
    output logic [NCH*REGW-1:0] refa_out,
    output logic [NCH*REGW-1:0] pre_out,
    output logic [NCH*REGW-1:0] refb_out
);
    localparam int BYTES = REGW / 8;
    localparam int PW    = $clog2(GROUPS * BYTES);
    localparam int RW    = (BYTES > 1) ? $clog2(BYTES) : 1;

    logic                  wr_done, rd_done;
    logic [NCH-1:0]        one_sel;
    logic [NCH-1:0][7:0]   rd_byte_all;
    logic [NCH-1:0][7:0]   status_all;
    logic [NCH-1:0][PW-1:0] wr_ptr_all;
    logic [NCH-1:0]        mode_all;

    bytebus_strobe_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .wr_done (wr_done),
        .rd_done (rd_done)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [GROUPS-1:0][REGW-1:0] grp_val;

        bytebus_chan_regs #(.REGW(REGW), .PW(PW), .RW(RW)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (!ce_n[i]),
            .rd_single (one_sel[i]),
            .cd        (cd),
            .din       (din),
            .wr_done   (wr_done),
            .rd_done   (rd_done),
            .latch     (latch_in[i*REGW +: REGW]),
            .grp_val   (grp_val),
            .wr_ptr    (wr_ptr_all[i]),
            .mode      (mode_all[i]),
            .rd_byte   (rd_byte_all[i]),
            .status    (status_all[i])
        );

        assign cnt_out [i*REGW +: REGW] = grp_val[0];
        assign refa_out[i*REGW +: REGW] = grp_val[1];
        assign pre_out [i*REGW +: REGW] = grp_val[2];
        assign refb_out[i*REGW +: REGW] = grp_val[3];
    end

    bytebus_rd_mux #(.NCH(NCH)) u_mux (
        .ce_n        (ce_n),
        .rd_n        (rd_n),
        .cd          (cd),
        .rd_byte_all (rd_byte_all),
        .status_all  (status_all),
        .one_sel     (one_sel),
        .dout        (dout),
        .dout_en     (dout_en)
    );
endmodule

// File: rtl/bytebus_ptr_chk.sv
module bytebus_ptr_chk #(
    parameter int NCH  = 4,
    parameter int REGW = 24,
    parameter int PW   = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         ce_n,
    input logic                   wr_n,
    input logic                   rd_n,
    input logic                   dout_en,
    input logic [NCH*REGW-1:0]    cnt_out,
    input logic [NCH*REGW-1:0]    refa_out,
    input logic [NCH*REGW-1:0]    pre_out,
    input logic [NCH*REGW-1:0]    refb_out,
    input logic [NCH-1:0][PW-1:0] wr_ptr_all,
    input logic [NCH-1:0]         mode_all
);
    localparam int BYTES = REGW / 8;
    localparam logic [PW-1:0] LAST0 = PW'(3 * BYTES - 1);
    localparam logic [PW-1:0] LAST1 = PW'(4 * BYTES - 1);

    // R9
    drive_needs_single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!rd_n && $countones(~ce_n) == 1));

    // R9
    idle_bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&ce_n) |-> !dout_en);

    // R10
    regs_hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_n, 2) |-> $stable({cnt_out, refa_out, pre_out, refb_out}));

    for (genvar i = 0; i < NCH; i++) begin : g_rng
        // R4 R5
        ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mode_all[i] ? (wr_ptr_all[i] <= LAST1) : (wr_ptr_all[i] <= LAST0));
    end
endmodule

bind bytebus_ptr_port bytebus_ptr_chk #(.NCH(NCH), .REGW(REGW), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .wr_n       (wr_n),
    .rd_n       (rd_n),
    .dout_en    (dout_en),
    .cnt_out    (cnt_out),
    .refa_out   (refa_out),
    .pre_out    (pre_out),
    .refb_out   (refb_out),
    .wr_ptr_all (wr_ptr_all),
    .mode_all   (mode_all)
);

// File: tb/bytebus_ptr_port_test.sv
module bytebus_ptr_port_test;
    localparam int NCH  = 4;
    localparam int REGW = 24;

    typedef struct {
        int          kind;   // 0 dout, 1 dout_en, 2 register
        int          ch;
        int          grp;
        logic [23:0] exp;
        string       req;
    } item_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NCH-1:0]      ce_n = '1;
    logic                cd = 1'b0;
    logic                wr_n = 1'b1;
    logic                rd_n = 1'b1;
    logic [7:0]          din = '0;
    logic [7:0]          dout;
    logic                dout_en;
    logic [NCH*REGW-1:0] latch_in;
    logic [NCH*REGW-1:0] cnt_out, refa_out, pre_out, refb_out;

    int    n_checks = 0;
    int    n_fail   = 0;
    item_t sb_q[$];
    event  sample_ev;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    bytebus_ptr_port #(.NCH(NCH), .REGW(REGW)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cd(cd), .wr_n(wr_n), .rd_n(rd_n),
        .din(din), .dout(dout), .dout_en(dout_en), .latch_in(latch_in),
        .cnt_out(cnt_out), .refa_out(refa_out), .pre_out(pre_out), .refb_out(refb_out)
    );

    function automatic logic [23:0] reg_val(int ch, int grp);
        case (grp)
            0:       return cnt_out [ch*REGW +: REGW];
            1:       return refa_out[ch*REGW +: REGW];
            2:       return pre_out [ch*REGW +: REGW];
            default: return refb_out[ch*REGW +: REGW];
        endcase
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [23:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = {16'h0, dout};
                    1:       act = {23'h0, dout_en};
                    default: act = reg_val(it.ch, it.grp);
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d ch=%0d grp=%0d actual=%h expected=%h",
                             it.req, it.kind, it.ch, it.grp, act, it.exp);
                end
            end
        end
    end

    task automatic push(int kind, int ch, int grp, logic [23:0] exp, string req);
        item_t it;
        it.kind = kind; it.ch = ch; it.grp = grp; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic do_write(logic [NCH-1:0] en, logic sel, logic [7:0] d, int hold = 1);
        @(negedge clk);
        ce_n = en; cd = sel; din = d; wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        ce_n = '1;
    endtask

    task automatic do_read(logic [NCH-1:0] en, logic sel, logic exp_en,
                           logic [7:0] exp_d, string req);
        @(negedge clk);
        ce_n = en; cd = sel; rd_n = 1'b0;
        @(negedge clk);
        push(1, 0, 0, {23'h0, exp_en}, req);
        if (exp_en) push(0, 0, 0, {16'h0, exp_d}, req);
        -> sample_ev;
        #1;
        rd_n = 1'b1;
        @(negedge clk);
        ce_n = '1;
    endtask

    task automatic check_reg(int ch, int grp, logic [23:0] exp, string req);
        @(negedge clk);
        push(2, ch, grp, exp, req);
        -> sample_ev;
        #1;
    endtask

    initial begin
        latch_in = {24'hF0E0D0, 24'hC3B2A1, 24'h9A8877, 24'h563412};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        do_read(4'b1110, 1'b1, 1'b1, 8'h00, "R1 status after reset");
        check_reg(0, 0, 24'h0, "R1 counter reg after reset");
        check_reg(3, 3, 24'h0, "R1 refB reg after reset");

        // R3: nine data bytes in mode 0
        for (int k = 0; k < 9; k++) do_write(4'b1110, 1'b0, 8'h11 + 8'(k));
        check_reg(0, 0, 24'h131211, "R3 counter bytes");
        check_reg(0, 1, 24'h161514, "R3 refA bytes");
        check_reg(0, 2, 24'h191817, "R3 preload bytes");
        // R4: wrap after index 8 in mode 0
        do_read(4'b1110, 1'b1, 1'b1, 8'h00, "R4 pointer wrapped to 0");
        do_write(4'b1110, 1'b0, 8'h2A);
        check_reg(0, 0, 24'h13122A, "R4 wrap rewrites counter low");
        check_reg(0, 3, 24'h0, "R4 refB untouched in mode 0");

        // R2 / R5: mode 1, start at preload low
        do_write(4'b1110, 1'b1, 8'h16);
        do_read(4'b1110, 1'b1, 1'b1, 8'h16, "R2 command sets pointer and mode");
        for (int k = 0; k < 6; k++) do_write(4'b1110, 1'b0, 8'h31 + 8'(k));
        check_reg(0, 2, 24'h333231, "R5 preload in mode 1");
        check_reg(0, 3, 24'h363534, "R5 refB in mode 1");
        do_read(4'b1110, 1'b1, 1'b1, 8'h10, "R5 wrap after index 11");

        // R2: out-of-range start for mode 0
        do_write(4'b1110, 1'b1, 8'h0A);
        do_read(4'b1110, 1'b1, 1'b1, 8'h00, "R2 out-of-range start loads 0");

        // R6 / R7: capture reads and status reads
        do_read(4'b1110, 1'b0, 1'b1, 8'h12, "R6 capture low byte");
        do_read(4'b1110, 1'b1, 1'b1, 8'h20, "R7 status shows read index 1");
        do_read(4'b1110, 1'b1, 1'b1, 8'h20, "R7 status read leaves index");
        do_read(4'b1110, 1'b0, 1'b1, 8'h34, "R6 capture middle byte");
        do_read(4'b1110, 1'b0, 1'b1, 8'h56, "R6 capture high byte");
        do_read(4'b1110, 1'b0, 1'b1, 8'h12, "R6 capture index wraps");
        do_write(4'b1110, 1'b1, 8'h00);
        do_read(4'b1110, 1'b1, 1'b1, 8'h00, "R2 command clears read index");

        // R8: broadcast to channels 1 and 3
        do_write(4'b0101, 1'b1, 8'h03);
        do_write(4'b0101, 1'b0, 8'hAB);
        check_reg(1, 1, 24'h0000AB, "R8 broadcast reaches ch1");
        check_reg(3, 1, 24'h0000AB, "R8 broadcast reaches ch3");
        check_reg(0, 1, 24'h161514, "R8 ch0 unchanged");
        check_reg(2, 1, 24'h000000, "R8 ch2 unchanged");
        do_read(4'b1101, 1'b1, 1'b1, 8'h04, "R8 ch1 pointer stepped");

        // R9: reads with several or no enables
        do_read(4'b1100, 1'b0, 1'b0, 8'h00, "R9 two enables drive nothing");
        do_read(4'b1111, 1'b0, 1'b0, 8'h00, "R9 no enable drives nothing");
        do_read(4'b1101, 1'b0, 1'b1, 8'h77, "R9 ignored reads kept ch1 index");

        // R10: strobe held low performs one access
        do_write(4'b1011, 1'b0, 8'h5C, 6);
        check_reg(2, 0, 24'h00005C, "R10 held strobe writes once");
        do_read(4'b1011, 1'b1, 1'b1, 8'h01, "R10 pointer advanced once");

        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule